// File: doc/BRIEF.md
# Dual-Rate Reference Clock Generator

This block derives the two reference clocks that a 10/100 line interface needs from a single 50 MHz source. It is written as clock-enable logic on a fast base clock. Each cycle of the 50 MHz source arrives as a one-cycle `tick50_i` pulse. Every output is a registered level on the base clock. A divide-by-two produces the 25 MHz reference, and a fractional divide-by-2.5 produces an internal 20 MHz reference.

The 10 Mb/s reference `ref10_o` comes from an externally supplied 20 MHz level whenever that input shows activity. Otherwise it comes from the internal fractional divider. An activity monitor counts source ticks between rising edges of the synchronised external input and decides whether that input is alive. A selector moves to the chosen source only while both candidates are low, so no runt pulse appears on `ref10_o`. The 25 MHz output can be gated low when the board does not use it.

Top module: `refclk_gen`

## Requirements
- R1: While enabled, `clk25_o` inverts once in the cycle after every base cycle with `tick50_i` high, and it is otherwise stable.
- R2: `int20_o` follows the repeating five-tick pattern high, low, low, high, low, counted from reset. It steps one position per tick, which gives two high pulses every five ticks.
- R3: Once 16 ticks have passed since the last rising edge of the synchronised external input, `ext_active_o` goes low.
- R4: From the inactive state, `ext_active_o` goes high after 4 rising edges with no 16-tick gap between them. A gap restarts the edge count.
- R5: `ref10_o` equals the external input delayed by two base-clock synchroniser stages when `sel_ext_o` is high, and equals `int20_o` when it is low. `sel_ext_o` moves toward `ext_active_o`.
- R6: `sel_ext_o` changes only in the cycle after one in which both the synchronised external level and `int20_o` were low.
- R7: With `en25_i` low, `clk25_o` stays low, while the divide-by-two keeps counting underneath.
- R8: After reset, `clk25_o` is low, `int20_o` is high, `ext_active_o` is low and `sel_ext_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick50_i | input | 1 | One pulse per 50 MHz source cycle |
| ext20_i | input | 1 | External 20 MHz reference level, asynchronous |
| en25_i | input | 1 | Enable for the 25 MHz output |
| clk25_o | output | 1 | 25 MHz reference level |
| int20_o | output | 1 | Internally derived 20 MHz level |
| ref10_o | output | 1 | Selected 10 Mb/s reference |
| ext_active_o | output | 1 | External input judged active |
| sel_ext_o | output | 1 | External source currently driving `ref10_o` |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a 16-tick idle limit, four edges to activate, and a 5/2 fractional ratio. With the idle limit this small, several complete drop-and-recover cycles of the activity monitor fit in a short run. The bench covers a gap that cuts an activation sequence short, tick patterns with irregular spacing, and source switches that have to wait for both references to be low.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   // Bresenham-style spread of PULSES highs over PERIOD ticks
   function automatic logic frac_high(input int phase, input int period, input int pulses);
      return ((phase * pulses) % period) < pulses;
   endfunction
endpackage

// File: rtl/refclk_div2.sv
module refclk_div2 (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   output logic clk_o
);
   logic q;

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= 1'b0;
      else if (tick) q <= ~q;
   end

   assign clk_o = en & q;

   assert_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (q != $past(q)));
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(q));
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div #(
   parameter int PERIOD = 5,
   parameter int PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic clk_o
);
   import refclk_pkg::*;
   localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   if (PULSES < 1 || 2 * PULSES > PERIOD) begin : g_bad_ratio
      $error("refclk_frac_div: PULSES must be in 1..PERIOD/2");
   end

   logic [PERIOD-1:0] pattern;
   logic [PW-1:0]     phase;

   for (genvar i = 0; i < PERIOD; i++) begin : g_pat
      assign pattern[i] = frac_high(i, PERIOD, PULSES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= '0;
      else if (tick) phase <= (phase == PW'(PERIOD-1)) ? '0 : phase + 1'b1;
   end

   assign clk_o = pattern[phase];

   assert_no_double_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clk_o) |=> !clk_o);
endmodule

// File: rtl/refclk_activity_mon.sv
module refclk_activity_mon #(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_LIMIT  = 16,
   parameter int ACT_EDGES   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ext_i,
   output logic ext_s,
   output logic active
);
   localparam int SW = $clog2(IDLE_LIMIT + 1);
   localparam int EW = $clog2(ACT_EDGES + 1);

   if (SYNC_STAGES < 2)  begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (IDLE_LIMIT < 2)   begin : g_bad_idle  $error("IDLE_LIMIT must be at least 2"); end
   if (ACT_EDGES < 1)    begin : g_bad_edges $error("ACT_EDGES must be at least 1"); end

   logic [SYNC_STAGES-1:0] sync;
   logic                   prev;
   logic [SW-1:0]          silent;
   logic [EW-1:0]          ecnt;
   logic                   rise;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) sync[s] <= 1'b0;
         else        sync[s] <= (s == 0) ? ext_i : sync[(s == 0) ? 0 : s-1];
      end
   end

   assign ext_s = sync[SYNC_STAGES-1];
   assign rise  = ext_s & ~prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev   <= 1'b0;
         silent <= '0;
         ecnt   <= '0;
         active <= 1'b0;
      end else begin
         prev <= ext_s;
         if (rise) begin
            silent <= '0;
            if (!active) begin
               if (ecnt == EW'(ACT_EDGES-1)) begin
                  active <= 1'b1;
                  ecnt   <= '0;
               end else begin
                  ecnt <= ecnt + 1'b1;
               end
            end
         end else if (tick && silent != SW'(IDLE_LIMIT)) begin
            silent <= silent + 1'b1;
            if (silent == SW'(IDLE_LIMIT-1)) begin
               active <= 1'b0;
               ecnt   <= '0;
            end
         end
      end
   end

   assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !rise) |=> !active);
   assert_drop_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick) |=> active);
endmodule

// File: rtl/refclk_switch.sv
module refclk_switch (
   input  logic clk,
   input  logic rst_n,
   input  logic want_ext,
   input  logic ext_s,
   input  logic int_clk,
   output logic sel,
   output logic ref_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) sel <= 1'b0;
      else if (sel != want_ext && !ext_s && !int_clk) sel <= want_ext;
   end

   assign ref_o = sel ? ext_s : int_clk;

   assert_quiet_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_s || int_clk) |=> $stable(sel));
   assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == want_ext) |=> (sel == $past(want_ext)) || (sel == $past(sel)));
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen #(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_LIMIT  = 16,
   parameter int ACT_EDGES   = 4,
   parameter int FRAC_PERIOD = 5,
   parameter int FRAC_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick50_i,
   input  logic ext20_i,
   input  logic en25_i,
   output logic clk25_o,
   output logic int20_o,
   output logic ref10_o,
   output logic ext_active_o,
   output logic sel_ext_o
);
   logic ext_s;

   refclk_div2 u_div2 (
      .clk(clk), .rst_n(rst_n), .tick(tick50_i), .en(en25_i), .clk_o(clk25_o)
   );

   refclk_frac_div #(.PERIOD(FRAC_PERIOD), .PULSES(FRAC_PULSES)) u_frac (
      .clk(clk), .rst_n(rst_n), .tick(tick50_i), .clk_o(int20_o)
   );

   refclk_activity_mon #(
      .SYNC_STAGES(SYNC_STAGES), .IDLE_LIMIT(IDLE_LIMIT), .ACT_EDGES(ACT_EDGES)
   ) u_mon (
      .clk(clk), .rst_n(rst_n), .tick(tick50_i), .ext_i(ext20_i),
      .ext_s(ext_s), .active(ext_active_o)
   );

   refclk_switch u_sw (
      .clk(clk), .rst_n(rst_n), .want_ext(ext_active_o), .ext_s(ext_s),
      .int_clk(int20_o), .sel(sel_ext_o), .ref_o(ref10_o)
   );

   assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en25_i |=> (!en25_i -> !clk25_o));
endmodule

// File: tb/refclk_gen_tb.sv
module refclk_gen_tb;
   logic clk = 0, rst_n = 0, tick = 0, ext = 0, en25 = 1;
   logic clk25, int20, ref10, act, sel;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   refclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .tick50_i(tick), .ext20_i(ext), .en25_i(en25),
      .clk25_o(clk25), .int20_o(int20), .ref10_o(ref10),
      .ext_active_o(act), .sel_ext_o(sel)
   );

   // behavioural model state
   int m_q25, m_phase, m_prev, m_silent, m_ecnt, m_act, m_sel;
   int syncq[$];
   int ext_phase = 0;
   int high_seen = 0;
   logic [7:0] lfsr = 8'h5a;

   function automatic int pat(int p);
      return (p == 0 || p == 3) ? 1 : 0;
   endfunction

   task automatic check(input bit ok, input string tag, input int actual, input int expected);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expected, $time);
      end
   endtask

   task automatic model_reset();
      m_q25 = 0; m_phase = 0; m_prev = 0; m_silent = 0; m_ecnt = 0; m_act = 0; m_sel = 0;
      syncq = '{0, 0};
   endtask

   task automatic compare_all();
      int es = syncq[1];
      int i20 = pat(m_phase);
      check(clk25 == (en25 & m_q25), en25 ? "R1" : "R7", clk25, en25 & m_q25);
      check(int20 == i20, "R2", int20, i20);
      check(act == m_act, "R3/R4", act, m_act);
      check(sel == m_sel, "R6", sel, m_sel);
      check(ref10 == (m_sel ? es : i20), "R5", ref10, m_sel ? es : i20);
   endtask

   task automatic model_step();
      int es = syncq[1];
      int i20 = pat(m_phase);
      int rise = es && !m_prev;
      int n_act = m_act, n_ecnt = m_ecnt, n_sil = m_silent;
      if (rise) begin
         n_sil = 0;
         if (!m_act) begin
            if (m_ecnt == 3) begin n_act = 1; n_ecnt = 0; end
            else n_ecnt = m_ecnt + 1;
         end
      end else if (tick && m_silent != 16) begin
         n_sil = m_silent + 1;
         if (n_sil == 16) begin n_act = 0; n_ecnt = 0; end
      end
      if (m_sel != m_act && !es && !i20) m_sel = m_act;
      m_act = n_act; m_ecnt = n_ecnt; m_silent = n_sil; m_prev = es;
      if (tick) begin m_q25 ^= 1; m_phase = (m_phase + 1) % 5; end
      syncq = '{ext, syncq[0]};
   endtask

   // mode: 0 ext idle low, 1 ext running, 2 ext bursts with gap
   task automatic run(input int cycles, input int mode, input bit irregular);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         compare_all();
         if (int20) high_seen++;
         if (irregular) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick = lfsr[0];
         end else tick = ~tick;
         ext_phase = (ext_phase + 1) % 5;
         case (mode)
            1: ext = (ext_phase < 2);
            2: ext = (c % 60 < 12) ? (ext_phase < 2) : 1'b0;
            default: ext = 1'b0;
         endcase
         model_step();
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      // R8: reset state
      check(clk25 == 0, "R8", clk25, 0);
      check(int20 == 1, "R8", int20, 1);
      check(act == 0, "R8", act, 0);
      check(sel == 0, "R8", sel, 0);
      rst_n = 1;
      model_step();
      // R2: ten ticks on a steady cadence give four highs
      high_seen = 0;
      run(20, 0, 0);
      check(high_seen == 8, "R2", high_seen, 8);
      // R4/R5: bring the external input alive
      run(120, 1, 0);
      check(act == 1, "R4", act, 1);
      check(sel == 1, "R5", sel, 1);
      // R7: gate the 25 MHz output
      en25 = 0;
      run(30, 1, 0);
      check(clk25 == 0, "R7", clk25, 0);
      en25 = 1;
      run(10, 1, 0);
      // R3: external stops, 16 ticks later it is dropped
      run(60, 0, 0);
      check(act == 0, "R3", act, 0);
      check(sel == 0, "R6", sel, 0);
      // R4: bursts interrupted by gaps, then irregular ticks
      run(300, 2, 0);
      run(300, 1, 1);
      run(200, 0, 1);
      run(200, 1, 0);
      check(act == 1, "R4", act, 1);
      // mid-run reset returns to R8 state
      @(negedge clk);
      rst_n = 0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      check(act == 0 && sel == 0 && int20 == 1 && clk25 == 0, "R8", {act, sel, int20, clk25}, 2);
      rst_n = 1;
      tick = 0;
      model_step();
      run(100, 1, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule